// File: doc/BRIEF.md
# SCSI Initiator Register Interface

This block is the byte-wide host front end of a SCSI bus initiator. A host reaches eight registers through a 3-bit address. A read and a write at the same offset usually reach different functions. The block holds four registers: an output data latch, an initiator command register, a mode register and a target command register. It builds two status bytes from the sampled SCSI control lines. It drives the SCSI data and control lines as open-drain style enables, so a 1 means "pull the line".

The arbitration sequencer and the DMA handshake engine are separate blocks. This block gives them one-cycle trigger strobes and level flags, and takes back from them an arbitration-done pulse and a DMA-request level. The phase-match flag is a live comparison between the bus information-transfer lines and the expected phase held in the target command register. While DMA mode is enabled, this flag also guards the transfer.

All bus inputs are active-high after the receivers. The `bus_ctl_i` bit order is: 9 RST, 8 BSY, 7 REQ, 6 MSG, 5 C/D, 4 I/O, 3 SEL, 2 data parity, 1 ATN, 0 ACK. The `bus_ctl_oe` bit order is: 4 RST, 3 ACK, 2 BSY, 1 SEL, 0 ATN.

Top module: `scsi_init_regif`

## Requirements
- R1: Reads decode `host_addr` combinationally onto `host_rdata`, as follows:
  - Offset 0 returns `bus_data_i`.
  - Offset 1 returns the initiator command register.
  - Offset 2 returns the mode register.
  - Offset 3 returns the target command register.
  - Offset 4 returns the status byte.
  - Offset 5 returns the bus-and-status byte.
  - Offsets 6 and 7 return 0x00.
- R2: A write to offset 1 stores the written byte ANDed with 0x9F. This clears bit 6 (arbitration in progress) and bit 5 (arbitration lost).
- R3: `bus_ctl_oe` follows the stored initiator command bits from the clock edge after the write, as follows:
  - RST follows bit 7.
  - ACK follows bit 4.
  - BSY follows bit 3.
  - SEL follows bit 2.
  - ATN follows bit 1.
- R4: A write to offset 0 loads the output data latch, and `bus_data_o` shows the latch. `bus_data_oe` equals initiator command bit 0. While that bit is set, a write to offset 0 reaches `bus_data_o` after the next edge.
- R5: The status byte is built from the live bus lines, with this bit order: 7 RST, 6 BSY, 5 REQ, 4 MSG, 3 C/D, 2 I/O, 1 SEL, 0 data parity.
- R6: The bus-and-status byte has this bit order:
  - Bit 7 is end of DMA.
  - Bit 6 is `dma_drq_i`.
  - Bits 5, 4 and 2 read 0.
  - Bit 3 is phase match.
  - Bit 1 is live ATN.
  - Bit 0 is live ACK.
- R7: Phase match, which appears on `phase_match_o` and in bus-and-status bit 3, is 1 exactly when the bus MSG, C/D and I/O lines equal target command bits 2, 1 and 0. It tracks both the bus lines and target command writes.
- R8: The mode register (offset 2) and the target command register (offset 3) store all 8 written bits. Mode bit 1 is DMA mode, which appears on `dma_mode_o`. Mode bit 0 is arbitrate.
- R9: A write to offset 2 that changes mode bit 0 from 0 to 1 is judged in that same cycle. If bus SEL is asserted and initiator command bit 2 is clear, arbitration is lost: command bit 5 is set, bit 6 is cleared, and no strobe is issued. Otherwise `arb_start_o` pulses, bit 6 is set and bit 5 is cleared. `arb_done_i` clears bit 6.
- R10: While mode bit 1 is set or being written, DMA ends if BSY is low or phase match is 0. In that case mode bit 1 is clear and end-of-DMA is set after the next edge. A mode write with bit 1 set clears end-of-DMA.
- R11: Writes produce single-cycle strobes: offset 4 gives `sel_en_stb_o`, offset 5 gives `dma_send_stb_o`, offset 6 gives `dma_trx_stb_o` and offset 7 gives `dma_irx_stb_o`. A read of offset 7 gives `par_clr_stb_o`.
- R12: Reset (`rst_n` low) clears every register and releases all bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write enable for one cycle |
| host_rd | input | 1 | Read enable for one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| bus_data_i | input | 8 | Sampled SCSI data lines |
| bus_ctl_i | input | 10 | Sampled SCSI control lines |
| bus_data_o | output | 8 | Data to drive onto the bus |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_ctl_oe | output | 5 | Control line pull enables |
| arb_done_i | input | 1 | Arbitration sequencer finished |
| dma_drq_i | input | 1 | DMA engine request level |
| arb_start_o | output | 1 | Start-arbitration strobe |
| dma_mode_o | output | 1 | DMA mode enabled |
| phase_match_o | output | 1 | Live phase match |
| sel_en_stb_o | output | 1 | Select-enable write strobe |
| dma_send_stb_o | output | 1 | Start DMA send strobe |
| dma_trx_stb_o | output | 1 | Start DMA target receive strobe |
| dma_irx_stb_o | output | 1 | Start DMA initiator receive strobe |
| par_clr_stb_o | output | 1 | Parity/IRQ reset read strobe |

## Verification
Four properties are checked on every cycle:
- Control line enables change only after an initiator command write.
- A data latch write reaches the bus while driving is enabled.
- An arbitration request ends in exactly one of the won and lost outcomes.
- A broken phase or a dropped BSY ends DMA mode and sets end-of-DMA.

Only the bench scenarios can show the rest. These are the read decode at every offset, the exact bit layout of both status bytes, the 0x9F write mask, and phase match tracking the bus lines as they change.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int NREG   = 1 << ADDR_W;
  localparam int CTL_W  = 10;
  localparam int OE_W   = 5;

  // host register offsets
  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_ICR   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TCR   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_BAS   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_IDATA = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_PRST  = 3'd7;

  // initiator command bits
  localparam int ICR_RST  = 7;
  localparam int ICR_ARB  = 6;
  localparam int ICR_LOST = 5;
  localparam int ICR_ACK  = 4;
  localparam int ICR_BSY  = 3;
  localparam int ICR_SEL  = 2;
  localparam int ICR_ATN  = 1;
  localparam int ICR_DRV  = 0;
  localparam logic [DATA_W-1:0] ICR_KEEP = 8'h9F;

  // mode bits
  localparam int MODE_DMA = 1;
  localparam int MODE_ARB = 0;

  // sampled bus control vector positions
  localparam int BC_RST = 9;
  localparam int BC_BSY = 8;
  localparam int BC_MSG = 6;
  localparam int BC_CD  = 5;
  localparam int BC_IO  = 4;
  localparam int BC_SEL = 3;
  localparam int BC_ATN = 1;
  localparam int BC_ACK = 0;

  function automatic logic phase_eq(input logic [2:0] bus_ph,
                                    input logic [2:0] want_ph);
    return bus_ph == want_ph;
  endfunction

  function automatic logic [OE_W-1:0] ctl_from_icr(input logic [DATA_W-1:0] icr);
    return {icr[ICR_RST], icr[ICR_ACK], icr[ICR_BSY], icr[ICR_SEL], icr[ICR_ATN]};
  endfunction

  function automatic logic [DATA_W-1:0] pack_bas(input logic eod, input logic drq,
                                                 input logic pm, input logic atn,
                                                 input logic ack);
    return {eod, drq, 1'b0, 1'b0, pm, 1'b0, atn, ack};
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic [CTL_W-1:0] ctl);
    return ctl[CTL_W-1:2];
  endfunction

endpackage

// File: rtl/regif_decode.sv
module regif_decode
  import scsi_regif_pkg::*;
#(
  parameter int AW = ADDR_W,
  localparam int NR = 1 << AW
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic [NR-1:0] wr_hit,
  output logic          rd_last
);

  for (genvar g = 0; g < NR; g++) begin : g_hit
    assign wr_hit[g] = wr && (addr == AW'(g));
  end

  assign rd_last = rd && (addr == AW'(NR - 1));

endmodule

// File: rtl/regif_regs.sv
module regif_regs
  import scsi_regif_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_icr,
  input  logic          wr_mode,
  input  logic          wr_tcr,
  input  logic [DW-1:0] wdata,
  input  logic          bus_sel,
  input  logic          bus_bsy,
  input  logic          phase_ok,
  input  logic          arb_done,
  output logic [DW-1:0] odr_q,
  output logic [DW-1:0] icr_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] tcr_q,
  output logic          eod_q,
  output logic          arb_start
);

  logic [DW-1:0] icr_d, mode_d;
  logic          eod_d, dma_stop, arb_lost_now;

  always_comb begin
    icr_d        = icr_q;
    mode_d       = mode_q;
    eod_d        = eod_q;
    arb_start    = 1'b0;
    arb_lost_now = 1'b0;
    if (arb_done) icr_d[ICR_ARB] = 1'b0;
    if (wr_icr)   icr_d = wdata & ICR_KEEP;
    if (wr_mode) begin
      mode_d = wdata;
      if (wdata[MODE_DMA]) eod_d = 1'b0;
      if (wdata[MODE_ARB] && !mode_q[MODE_ARB]) begin
        if (bus_sel && !icr_q[ICR_SEL]) begin
          arb_lost_now    = 1'b1;
          icr_d[ICR_LOST] = 1'b1;
          icr_d[ICR_ARB]  = 1'b0;
        end else begin
          arb_start       = 1'b1;
          icr_d[ICR_LOST] = 1'b0;
          icr_d[ICR_ARB]  = 1'b1;
        end
      end
    end
    dma_stop = mode_d[MODE_DMA] && (!bus_bsy || !phase_ok);
    if (dma_stop) begin
      mode_d[MODE_DMA] = 1'b0;
      eod_d            = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q  <= '0;
      icr_q  <= '0;
      mode_q <= '0;
      tcr_q  <= '0;
      eod_q  <= 1'b0;
    end else begin
      if (wr_data) odr_q <= wdata;
      if (wr_tcr)  tcr_q <= wdata;
      icr_q  <= icr_d;
      mode_q <= mode_d;
      eod_q  <= eod_d;
    end
  end

  AST_ARB_WON: assert property (@(posedge clk) disable iff (!rst_n)
    arb_start |=> (icr_q[ICR_ARB] && !icr_q[ICR_LOST])); // R9

  AST_ARB_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_now |=> (icr_q[ICR_LOST] && !icr_q[ICR_ARB])); // R9

  AST_DMA_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_DMA] && !wr_mode && (!bus_bsy || !phase_ok))
      |=> (!mode_q[MODE_DMA] && eod_q)); // R10

endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
  import scsi_regif_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CTL_W
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_data,
  input  logic [CW-1:0] bus_ctl,
  input  logic [DW-1:0] icr,
  input  logic [DW-1:0] mode,
  input  logic [DW-1:0] tcr,
  input  logic          eod,
  input  logic          drq,
  input  logic          pm,
  output logic [DW-1:0] rdata
);

  always_comb begin
    unique case (addr)
      OFS_DATA:  rdata = bus_data;
      OFS_ICR:   rdata = icr;
      OFS_MODE:  rdata = mode;
      OFS_TCR:   rdata = tcr;
      OFS_STAT:  rdata = pack_status(bus_ctl);
      OFS_BAS:   rdata = pack_bas(eod, drq, pm, bus_ctl[BC_ATN], bus_ctl[BC_ACK]);
      OFS_IDATA: rdata = '0;
      OFS_PRST:  rdata = '0;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/scsi_init_regif.sv
module scsi_init_regif
  import scsi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [CTL_W-1:0]  bus_ctl_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic [OE_W-1:0]   bus_ctl_oe,
  input  logic              arb_done_i,
  input  logic              dma_drq_i,
  output logic              arb_start_o,
  output logic              dma_mode_o,
  output logic              phase_match_o,
  output logic              sel_en_stb_o,
  output logic              dma_send_stb_o,
  output logic              dma_trx_stb_o,
  output logic              dma_irx_stb_o,
  output logic              par_clr_stb_o
);

  logic [NREG-1:0]   wr_hit;
  logic [DATA_W-1:0] odr_q, icr_q, mode_q, tcr_q;
  logic              eod_q, phase_ok;

  regif_decode #(.AW(ADDR_W)) u_dec (
    .addr    (host_addr),
    .wr      (host_wr),
    .rd      (host_rd),
    .wr_hit  (wr_hit),
    .rd_last (par_clr_stb_o)
  );

  // live phase compare: target command bits 2,1,0 = MSG, C/D, I/O
  assign phase_ok = phase_eq({bus_ctl_i[BC_MSG], bus_ctl_i[BC_CD], bus_ctl_i[BC_IO]},
                             tcr_q[2:0]);

  regif_regs #(.DW(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_hit[OFS_DATA]),
    .wr_icr    (wr_hit[OFS_ICR]),
    .wr_mode   (wr_hit[OFS_MODE]),
    .wr_tcr    (wr_hit[OFS_TCR]),
    .wdata     (host_wdata),
    .bus_sel   (bus_ctl_i[BC_SEL]),
    .bus_bsy   (bus_ctl_i[BC_BSY]),
    .phase_ok  (phase_ok),
    .arb_done  (arb_done_i),
    .odr_q     (odr_q),
    .icr_q     (icr_q),
    .mode_q    (mode_q),
    .tcr_q     (tcr_q),
    .eod_q     (eod_q),
    .arb_start (arb_start_o)
  );

  regif_rdmux #(.AW(ADDR_W), .DW(DATA_W), .CW(CTL_W)) u_rd (
    .addr     (host_addr),
    .bus_data (bus_data_i),
    .bus_ctl  (bus_ctl_i),
    .icr      (icr_q),
    .mode     (mode_q),
    .tcr      (tcr_q),
    .eod      (eod_q),
    .drq      (dma_drq_i),
    .pm       (phase_ok),
    .rdata    (host_rdata)
  );

  assign bus_data_o     = odr_q;
  assign bus_data_oe    = icr_q[ICR_DRV];
  assign bus_ctl_oe     = ctl_from_icr(icr_q);
  assign dma_mode_o     = mode_q[MODE_DMA];
  assign phase_match_o  = phase_ok;
  assign sel_en_stb_o   = wr_hit[OFS_STAT];
  assign dma_send_stb_o = wr_hit[OFS_BAS];
  assign dma_trx_stb_o  = wr_hit[OFS_IDATA];
  assign dma_irx_stb_o  = wr_hit[OFS_PRST];

  AST_CTL_ONLY_ON_ICR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_ctl_oe) |-> $past(host_wr && host_addr == OFS_ICR)); // R3

  AST_ODR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_DATA && bus_data_oe)
      |=> (bus_data_oe && bus_data_o == $past(host_wdata))); // R4

endmodule

// File: tb/test_scsi_init_regif.sv
module test_scsi_init_regif;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [7:0] bus_data_i = '0, bus_data_o;
  logic       bus_data_oe;
  logic [4:0] bus_ctl_oe;
  logic       arb_done_i = 1'b0, dma_drq_i = 1'b0;
  logic       arb_start_o, dma_mode_o, phase_match_o;
  logic       sel_en_stb_o, dma_send_stb_o, dma_trx_stb_o, dma_irx_stb_o, par_clr_stb_o;

  logic b_rst = 0, b_bsy = 0, b_req = 0, b_msg = 0, b_cd = 0, b_io = 0;
  logic b_sel = 0, b_dbp = 0, b_atn = 0, b_ack = 0;
  logic [9:0] bus_ctl_i;
  assign bus_ctl_i = {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_dbp, b_atn, b_ack};

  always #2.5 clk = ~clk;

  scsi_init_regif i_scsi_init_regif (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       exp_eod = 0;
  logic [7:0] exp_tcr = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (host_rd && exp_q.size() > 0) begin
      check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
    @(posedge clk); #1;
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic wr_strobe(logic [2:0] a, logic [7:0] d, logic [4:0] exp, string req);
    @(posedge clk); #1;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #1;
    check(req, {3'b0, arb_start_o, sel_en_stb_o, dma_send_stb_o, dma_trx_stb_o, dma_irx_stb_o} & 8'h1F,
          {3'b0, exp});
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  function automatic logic [7:0] exp_bas();
    logic pm;
    pm = ({b_msg, b_cd, b_io} == exp_tcr[2:0]);
    return {exp_eod, dma_drq_i, 2'b00, pm, 1'b0, b_atn, b_ack};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    #1;
    check("R12 ctl_oe", {3'b0, bus_ctl_oe}, 8'h00);
    check("R12 data_oe", {7'b0, bus_data_oe}, 8'h00);
    rd(3'd1, 8'h00, "R12 icr");
    rd(3'd2, 8'h00, "R12 mode");
    rd(3'd3, 8'h00, "R12 tcr");

    // R4 data latch and drive
    wr(3'd0, 8'hA5);
    check("R4 oe off", {7'b0, bus_data_oe}, 8'h00);
    wr(3'd1, 8'h01);
    check("R4 oe on", {7'b0, bus_data_oe}, 8'h01);
    check("R4 data", bus_data_o, 8'hA5);
    wr(3'd0, 8'h3C);
    check("R4 live data", bus_data_o, 8'h3C);

    // R2 / R3 write mask and control lines
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h9F, "R2 mask");
    check("R3 all ctl", {3'b0, bus_ctl_oe}, 8'h1F);
    wr(3'd1, 8'h12);
    rd(3'd1, 8'h12, "R2 icr");
    check("R3 ack+atn", {3'b0, bus_ctl_oe}, 8'h09);
    check("R4 oe cleared", {7'b0, bus_data_oe}, 8'h00);

    // R5 / R1 live status and data
    bus_data_i = 8'h6E;
    b_rst = 1; b_req = 1; b_cd = 1; b_sel = 1; b_dbp = 1;
    rd(3'd4, 8'hAB, "R5 status");
    rd(3'd0, 8'h6E, "R1 bus data");
    b_rst = 0; b_req = 0; b_cd = 0; b_sel = 0; b_dbp = 0;
    b_bsy = 1; b_msg = 1; b_io = 1;
    rd(3'd4, 8'h54, "R5 status2");

    // R7 / R6 phase match and bus-and-status
    wr(3'd3, 8'h05); exp_tcr = 8'h05;
    rd(3'd3, 8'h05, "R8 tcr");
    check("R7 pm on", {7'b0, phase_match_o}, 8'h01);
    b_atn = 1; b_ack = 1;
    rd(3'd5, exp_bas(), "R6 bas match");
    b_cd = 1;
    #1 check("R7 pm off", {7'b0, phase_match_o}, 8'h00);
    rd(3'd5, exp_bas(), "R6 bas mismatch");
    b_cd = 0; b_atn = 0; b_ack = 0;

    // R1 / R11 zero reads and strobes
    rd(3'd6, 8'h00, "R1 idata");
    @(posedge clk); #1;
    host_addr = 3'd7; host_rd = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R1 prst");
    #1 check("R11 par clr", {7'b0, par_clr_stb_o}, 8'h01);
    @(posedge clk); #1 host_rd = 1'b0;
    wr_strobe(3'd4, 8'h11, 5'b01000, "R11 sel en");
    wr_strobe(3'd5, 8'h22, 5'b00100, "R11 dma send");
    wr_strobe(3'd6, 8'h33, 5'b00010, "R11 dma trx");
    wr_strobe(3'd7, 8'h44, 5'b00001, "R11 dma irx");

    // R8 mode readback
    wr(3'd2, 8'h84);
    rd(3'd2, 8'h84, "R8 mode");

    // R9 arbitration won, done, lost
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr_strobe(3'd2, 8'h01, 5'b10000, "R9 arb start");
    rd(3'd1, 8'h40, "R9 in progress");
    @(posedge clk); #1 arb_done_i = 1'b1;
    @(posedge clk); #1 arb_done_i = 1'b0;
    rd(3'd1, 8'h00, "R9 done");
    wr(3'd2, 8'h00);
    b_sel = 1;
    wr_strobe(3'd2, 8'h01, 5'b00000, "R9 no start");
    rd(3'd1, 8'h20, "R9 lost");
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h04);
    wr_strobe(3'd2, 8'h01, 5'b10000, "R9 own sel start");
    rd(3'd1, 8'h44, "R9 own sel");
    check("R3 sel", {3'b0, bus_ctl_oe}, 8'h02);
    b_sel = 0;

    // R10 DMA mode end on phase mismatch
    dma_drq_i = 1'b1;
    wr(3'd2, 8'h02);
    check("R8 dma_mode", {7'b0, dma_mode_o}, 8'h01);
    rd(3'd2, 8'h02, "R10 dma kept");
    rd(3'd5, exp_bas(), "R6 drq");
    @(posedge clk); #1 b_io = 0;
    @(posedge clk); #1;
    exp_eod = 1;
    check("R10 dma_mode off", {7'b0, dma_mode_o}, 8'h00);
    rd(3'd2, 8'h00, "R10 mode cleared");
    rd(3'd5, exp_bas(), "R10 eod");
    // R10 BSY loss ends DMA too, write clears eod first
    b_io = 1;
    wr(3'd2, 8'h02);
    exp_eod = 0;
    rd(3'd5, exp_bas(), "R10 eod cleared");
    @(posedge clk); #1 b_bsy = 0;
    @(posedge clk); #1;
    exp_eod = 1;
    rd(3'd2, 8'h00, "R10 bsy loss");
    rd(3'd5, exp_bas(), "R10 eod bsy");

    // R12 reset mid-run
    wr(3'd1, 8'h9F);
    @(posedge clk); #1 rst_n = 1'b0;
    #1;
    check("R12 ctl released", {3'b0, bus_ctl_oe}, 8'h00);
    check("R12 data released", {7'b0, bus_data_oe}, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1;
    rd(3'd1, 8'h00, "R12 icr again");
    rd(3'd3, 8'h00, "R12 tcr again");
    @(posedge clk); @(posedge clk);
    summary();
  end

endmodule